// File: doc/BRIEF.md
# CPU exception entry controller

This block sits next to a simple 32-bit RISC pipeline and carries out exception and interrupt entry in one clock. Each cycle it looks at three kinds of input. The first is the pipeline's current PC, status word and power-management word. The second is the delay-slot flag and any synchronous exception request with its cause code. The third is the device and timer interrupt lines, together with the configuration word and the vector-base word. From these it decides whether an entry happens. When one does, it commits every architectural side effect on the same edge.

The side effects are these. The saved PC is corrected for system calls and delay slots. The pre-entry status word is saved, and the status word is forced into a fixed supervisor pattern. The doze and sleep enables are cleared, and any load-link reservation is dropped. The block also builds a new fetch address. That address is the cause code shifted up by 8, with an optional base word OR-ed in and an optional high prefix.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A synchronous reset (rst high at an edge) gives these outputs: sr_o = 0x00000001 (supervisor only), pmr_o, epc_o, esr_o and eear_o zero, all strobes low, cause_o = 0, and fetch_pc_o = 0x100, OR-ed with vbase_i when cfg_i bit 6 is set.
- R2: On entry, epc_o becomes pc_i. For cause 12 (system call) it becomes pc_i + 4.
- R3: When dslot_i is high at entry, 4 is subtracted from epc_o, sr_o bit 13 is set and dslot_clr_o pulses. Otherwise sr_o bit 13 is cleared at entry.
- R4: For cause 7 (illegal instruction), eear_o is loaded with pc_i. For any other cause, and without an entry, eear_o holds.
- R5: On entry, esr_o takes sr_i. sr_o takes sr_i with bit 0 (supervisor) set and bits 1 (tick enable), 2 (interrupt enable), 5 (data MMU) and 6 (instruction MMU) cleared.
- R6: On entry, pmr_o takes pmr_i with bits 4 (doze) and 5 (sleep) cleared, and resv_clr_o pulses.
- R7: On entry, fetch_pc_o = cause << 8. It is OR-ed with vbase_i when cfg_i bit 6 is set, and with 0xF0000000 when sr_i bit 14 is set. Without an entry it holds.
- R8: A request whose code is 0 or 15 pulses err_o. The request itself causes no entry, so epc_o, esr_o, eear_o and fetch_pc_o hold unless an interrupt is taken in that cycle.
- R9: irq_dev_i is taken as cause 8 only while sr_i bit 2 is set. irq_tick_i is taken as cause 5 only while sr_i bit 1 is set. When both are accepted, the tick is taken.
- R10: A valid synchronous request (codes 1 to 14) wins over any interrupt in the same cycle, and its code becomes cause_o.
- R11: Every output is registered one edge after its inputs. take_o pulses for exactly the entry cycle. Without an entry, sr_o and pmr_o follow sr_i and pmr_i with one cycle of delay, and cause_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc_i | input | 32 | PC of the instruction at the entry point |
| sr_i | input | 32 | Current status word |
| pmr_i | input | 32 | Current power-management word |
| dslot_i | input | 1 | Instruction is in a delay slot |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 4 | Cause code of the request |
| irq_dev_i | input | 1 | Device interrupt line |
| irq_tick_i | input | 1 | Timer interrupt line |
| cfg_i | input | 32 | Configuration word (bit 6: vector base present) |
| vbase_i | input | 32 | Vector base word |
| take_o | output | 1 | Entry committed on the last edge |
| cause_o | output | 4 | Cause taken, 0 when none |
| err_o | output | 1 | Request with an unusable code |
| epc_o | output | 32 | Saved exception PC |
| esr_o | output | 32 | Saved status word |
| eear_o | output | 32 | Effective-address register |
| sr_o | output | 32 | Updated status word |
| pmr_o | output | 32 | Updated power-management word |
| dslot_clr_o | output | 1 | Clear the pipeline's delay-slot flag |
| resv_clr_o | output | 1 | Drop the load-link reservation |
| fetch_pc_o | output | 32 | New fetch address |

## Verification
Every result of this block appears exactly one clock edge after the inputs that caused it. This covers the strobes, the saved registers, the rewritten status and power words and the vector. The bench drives inputs on the falling edge. On the rising edge it advances a behavioural model from those same inputs, and on the next falling edge it compares all outputs with the model. The comparison therefore always falls half a cycle after the edge that updated the outputs. Directed cases cover the syscall and delay-slot offsets, illegal codes, interrupt gating and priority, and the vector base and prefix. A random run follows them.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int XLEN = 32,
  parameter int CW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] sr_i,
  input  logic [XLEN-1:0] pmr_i,
  input  logic            dslot_i,
  input  logic            exc_req_i,
  input  logic [CW-1:0]   exc_code_i,
  input  logic            irq_dev_i,
  input  logic            irq_tick_i,
  input  logic [XLEN-1:0] cfg_i,
  input  logic [XLEN-1:0] vbase_i,
  output logic            take_o,
  output logic [CW-1:0]   cause_o,
  output logic            err_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] esr_o,
  output logic [XLEN-1:0] eear_o,
  output logic [XLEN-1:0] sr_o,
  output logic [XLEN-1:0] pmr_o,
  output logic            dslot_clr_o,
  output logic            resv_clr_o,
  output logic [XLEN-1:0] fetch_pc_o
);
  localparam int SR_SM  = 0;
  localparam int SR_TEE = 1;
  localparam int SR_IEE = 2;
  localparam int SR_DME = 5;
  localparam int SR_IME = 6;
  localparam int SR_DSX = 13;
  localparam int SR_EPH = 14;
  localparam int PM_DOZE  = 4;
  localparam int PM_SLEEP = 5;
  localparam int CFG_VBP  = 6;

  localparam logic [CW-1:0] C_RESET   = CW'(1);
  localparam logic [CW-1:0] C_TICK    = CW'(5);
  localparam logic [CW-1:0] C_ILLEGAL = CW'(7);
  localparam logic [CW-1:0] C_DEVICE  = CW'(8);
  localparam logic [CW-1:0] C_SYSCALL = CW'(12);
  localparam logic [CW-1:0] C_LAST    = CW'(14);

  localparam logic [XLEN-1:0] HI_PREFIX = {4'hF, {(XLEN-4){1'b0}}};
  localparam logic [XLEN-1:0] SR_RST    = XLEN'(1) << SR_SM;
  localparam logic [XLEN-1:0] SR_CLR    = (XLEN'(1) << SR_TEE) | (XLEN'(1) << SR_IEE) |
                                          (XLEN'(1) << SR_DME) | (XLEN'(1) << SR_IME) |
                                          (XLEN'(1) << SR_DSX);
  localparam logic [XLEN-1:0] PM_CLR    = (XLEN'(1) << PM_DOZE) | (XLEN'(1) << PM_SLEEP);

  function automatic logic [XLEN-1:0] vector(input logic [CW-1:0] c,
                                             input logic [XLEN-1:0] sr,
                                             input logic [XLEN-1:0] cfg,
                                             input logic [XLEN-1:0] base);
    logic [XLEN-1:0] v;
    v = XLEN'(c) << 8;
    if (cfg[CFG_VBP]) v = v | base;
    if (sr[SR_EPH])   v = v | HI_PREFIX;
    return v;
  endfunction

  logic          code_ok, sync_ok, dev_ok, tick_ok, take_n;
  logic [CW-1:0] cause_n;
  logic [XLEN-1:0] epc_n, sr_n;

  assign code_ok = (exc_code_i != '0) && (exc_code_i <= C_LAST);
  assign sync_ok = exc_req_i && code_ok;
  assign dev_ok  = irq_dev_i && sr_i[SR_IEE];
  assign tick_ok = irq_tick_i && sr_i[SR_TEE];

  always_comb begin
    cause_n = '0;
    if (sync_ok)      cause_n = exc_code_i;
    else if (tick_ok) cause_n = C_TICK;
    else if (dev_ok)  cause_n = C_DEVICE;
  end

  assign take_n = cause_n != '0;

  assign epc_n = pc_i + ((cause_n == C_SYSCALL) ? XLEN'(4) : '0)
                      - (dslot_i ? XLEN'(4) : '0);

  assign sr_n = (sr_i & ~SR_CLR) | SR_RST | (XLEN'(dslot_i) << SR_DSX);

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o      <= 1'b0;
      cause_o     <= '0;
      err_o       <= 1'b0;
      epc_o       <= '0;
      esr_o       <= '0;
      eear_o      <= '0;
      sr_o        <= SR_RST;
      pmr_o       <= '0;
      dslot_clr_o <= 1'b0;
      resv_clr_o  <= 1'b0;
      fetch_pc_o  <= vector(C_RESET, SR_RST, cfg_i, vbase_i);
    end else begin
      take_o      <= take_n;
      cause_o     <= cause_n;
      err_o       <= exc_req_i && !code_ok;
      dslot_clr_o <= take_n && dslot_i;
      resv_clr_o  <= take_n;
      if (take_n) begin
        epc_o      <= epc_n;
        esr_o      <= sr_i;
        sr_o       <= sr_n;
        pmr_o      <= pmr_i & ~PM_CLR;
        fetch_pc_o <= vector(cause_n, sr_i, cfg_i, vbase_i);
        if (cause_n == C_ILLEGAL) eear_o <= pc_i;
      end else begin
        sr_o  <= sr_i;
        pmr_o <= pmr_i;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
  parameter int XLEN = 32,
  parameter int CW   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] sr_i,
  input logic            dslot_i,
  input logic            exc_req_i,
  input logic            irq_tick_i,
  input logic            take_o,
  input logic [CW-1:0]   cause_o,
  input logic            err_o,
  input logic [XLEN-1:0] epc_o,
  input logic [XLEN-1:0] esr_o,
  input logic [XLEN-1:0] eear_o,
  input logic [XLEN-1:0] sr_o,
  input logic [XLEN-1:0] pmr_o,
  input logic            dslot_clr_o,
  input logic            resv_clr_o,
  input logic [XLEN-1:0] fetch_pc_o
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_sup_mode_R5: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (sr_o[0] && !sr_o[1] && !sr_o[2] && !sr_o[5] && !sr_o[6]));

  assert_esr_copy_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    take_o |-> esr_o == $past(sr_i));

  assert_dsx_flag_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    take_o |-> (sr_o[13] == dslot_clr_o) && (dslot_clr_o == $past(dslot_i)));

  assert_power_resv_R6: assert property (@(posedge clk) disable iff (rst)
    take_o |-> resv_clr_o && !pmr_o[4] && !pmr_o[5]);

  assert_no_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> !resv_clr_o && !dslot_clr_o && cause_o == '0);

  assert_hold_saved_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    !take_o |-> $stable(epc_o) && $stable(esr_o) && $stable(eear_o) && $stable(fetch_pc_o));

  assert_vec_align_R7: assert property (@(posedge clk) disable iff (rst)
    take_o |-> fetch_pc_o[7:0] == 8'h00);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (err_o && take_o) |-> (cause_o == CW'(5) || cause_o == CW'(8)));

  assert_tick_wins_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    (take_o && $past(irq_tick_i && sr_i[1]) && !$past(exc_req_i)) |-> cause_o == CW'(5));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.XLEN(XLEN), .CW(CW)) chk_i (
  .clk(clk), .rst(rst), .sr_i(sr_i), .dslot_i(dslot_i), .exc_req_i(exc_req_i),
  .irq_tick_i(irq_tick_i), .take_o(take_o), .cause_o(cause_o), .err_o(err_o),
  .epc_o(epc_o), .esr_o(esr_o), .eear_o(eear_o), .sr_o(sr_o), .pmr_o(pmr_o),
  .dslot_clr_o(dslot_clr_o), .resv_clr_o(resv_clr_o), .fetch_pc_o(fetch_pc_o)
);

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] pc_i = 0, sr_i = 0, pmr_i = 0, cfg_i = 0, vbase_i = 0;
  logic dslot_i = 0, exc_req_i = 0, irq_dev_i = 0, irq_tick_i = 0;
  logic [3:0] exc_code_i = 0;
  logic take_o, err_o, dslot_clr_o, resv_clr_o;
  logic [3:0] cause_o;
  logic [31:0] epc_o, esr_o, eear_o, sr_o, pmr_o, fetch_pc_o;

  always #4 clk = ~clk;

  exc_entry_ctrl dut_i (
    .clk(clk), .rst(rst), .pc_i(pc_i), .sr_i(sr_i), .pmr_i(pmr_i), .dslot_i(dslot_i),
    .exc_req_i(exc_req_i), .exc_code_i(exc_code_i), .irq_dev_i(irq_dev_i),
    .irq_tick_i(irq_tick_i), .cfg_i(cfg_i), .vbase_i(vbase_i), .take_o(take_o),
    .cause_o(cause_o), .err_o(err_o), .epc_o(epc_o), .esr_o(esr_o), .eear_o(eear_o),
    .sr_o(sr_o), .pmr_o(pmr_o), .dslot_clr_o(dslot_clr_o), .resv_clr_o(resv_clr_o),
    .fetch_pc_o(fetch_pc_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  bit in_reset = 1;

  logic m_take, m_err, m_dclr, m_rclr;
  logic [3:0] m_cause;
  logic [31:0] m_epc, m_esr, m_eear, m_sr, m_pmr, m_fpc;

  function automatic logic [31:0] vec(input int c, input logic [31:0] sr,
                                      input logic [31:0] cfg, input logic [31:0] b);
    logic [31:0] v;
    v = 32'(c) * 256;
    if (cfg[6]) v = v | b;
    if (sr[14]) v = v | 32'hF000_0000;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_take = 0; m_err = 0; m_dclr = 0; m_rclr = 0; m_cause = 0;
      m_epc = 0; m_esr = 0; m_eear = 0; m_sr = 32'h1; m_pmr = 0;
      m_fpc = vec(1, 32'h1, cfg_i, vbase_i);
    end else begin
      int c;
      c = 0;
      if (exc_req_i && exc_code_i >= 1 && exc_code_i <= 14) c = exc_code_i;
      else if (irq_tick_i && sr_i[1]) c = 5;
      else if (irq_dev_i && sr_i[2]) c = 8;
      m_err = exc_req_i && (exc_code_i == 0 || exc_code_i == 15);
      m_take = (c != 0);
      m_cause = 4'(c);
      m_dclr = m_take && dslot_i;
      m_rclr = m_take;
      if (m_take) begin
        m_epc = pc_i;
        if (c == 12) m_epc = m_epc + 4;
        if (dslot_i) m_epc = m_epc - 4;
        m_esr = sr_i;
        m_sr = sr_i;
        m_sr[0] = 1; m_sr[1] = 0; m_sr[2] = 0; m_sr[5] = 0; m_sr[6] = 0;
        m_sr[13] = dslot_i;
        m_pmr = pmr_i; m_pmr[4] = 0; m_pmr[5] = 0;
        m_fpc = vec(c, sr_i, cfg_i, vbase_i);
        if (c == 7) m_eear = pc_i;
      end else begin
        m_sr = sr_i;
        m_pmr = pmr_i;
      end
    end
  end

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", in_reset ? "R1" : tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R11", "take_o", 32'(take_o), 32'(m_take));
    chk("R9 R10", "cause_o", 32'(cause_o), 32'(m_cause));
    chk("R8", "err_o", 32'(err_o), 32'(m_err));
    chk("R2 R3", "epc_o", epc_o, m_epc);
    chk("R5", "esr_o", esr_o, m_esr);
    chk("R4", "eear_o", eear_o, m_eear);
    chk("R5", "sr_o", sr_o, m_sr);
    chk("R6", "pmr_o", pmr_o, m_pmr);
    chk("R3", "dslot_clr_o", 32'(dslot_clr_o), 32'(m_dclr));
    chk("R6", "resv_clr_o", 32'(resv_clr_o), 32'(m_rclr));
    chk("R7", "fetch_pc_o", fetch_pc_o, m_fpc);
  endtask

  task automatic step(input logic req, input logic [3:0] code, input logic [31:0] pc,
                      input logic [31:0] sr, input logic ds, input logic dev, input logic tick);
    @(negedge clk);
    compare_all();
    exc_req_i = req; exc_code_i = code; pc_i = pc; sr_i = sr; dslot_i = ds;
    irq_dev_i = dev; irq_tick_i = tick;
  endtask

  initial begin
    pmr_i = 32'h0000_0037;
    repeat (3) begin @(negedge clk); compare_all(); end
    @(negedge clk); compare_all();
    rst = 0;
    in_reset = 0;
    step(0, 0, 32'h1000, 32'h0000_0066, 0, 0, 0);   // R11 idle follow-through
    step(1, 4'd2, 32'h2000, 32'h0000_6066, 0, 0, 0); // R2 R5 plain entry
    step(1, 4'd12, 32'h3000, 32'h0000_0006, 0, 0, 0);// R2 syscall +4
    step(1, 4'd12, 32'h3100, 32'h0000_0006, 1, 0, 0);// R3 syscall in delay slot
    step(1, 4'd7, 32'h4000, 32'h0000_2000, 1, 0, 0); // R4 illegal, R3 dslot
    step(1, 4'd0, 32'h5000, 32'h0, 0, 0, 0);         // R8 code 0
    step(1, 4'd15, 32'h5100, 32'h0, 0, 0, 0);        // R8 code 15
    step(1, 4'd15, 32'h5200, 32'h0000_0004, 0, 1, 0);// R8 with device taken
    step(0, 0, 32'h6000, 32'h0000_0002, 0, 1, 0);    // R9 device gated off
    step(0, 0, 32'h6100, 32'h0000_0004, 0, 1, 0);    // R9 device taken
    step(0, 0, 32'h6200, 32'h0000_0004, 0, 0, 1);    // R9 tick gated off
    step(0, 0, 32'h6300, 32'h0000_0006, 0, 1, 1);    // R9 tick wins
    step(1, 4'd3, 32'h6400, 32'h0000_0006, 0, 1, 1); // R10 sync wins
    step(1, 4'd14, 32'h7000, 32'h0000_4000, 0, 0, 0);// R7 high prefix
    cfg_i = 32'h40; vbase_i = 32'h1234_0000;
    step(1, 4'd9, 32'h7100, 32'h0, 0, 0, 0);         // R7 base OR-ed
    step(1, 4'd10, 32'h7200, 32'h0000_4000, 0, 0, 0);// R7 base and prefix
    step(0, 0, 32'h0, 32'h0, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      cfg_i = {25'd0, 1'($urandom), 6'd0};
      vbase_i = $urandom & 32'h0FFF_F000;
      pmr_i = $urandom;
      step(1'($urandom % 3 == 0), 4'($urandom), $urandom & 32'hFFFF_FFFC,
           $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
    end
    step(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); compare_all();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule